// File: doc/BRIEF.md
# Downstream Secondary Bus Reset Sequencer

This block sits on one downstream port of a PCIe switch model and carries that port through a secondary bus reset. Software starts the sequence by setting the port's reset control bit. The block then asks the link layer to send hot-reset training sets, but only while the link reports up. It drains the port's ingress queue one discard pulse per held packet. It then holds the port in reset until software clears the bit. After that, one resume cycle passes and the port returns to normal operation.

While the reset is in force, the block also tells the request path how to answer each incoming request. Type 0 configuration accesses aimed at the port's own bridge complete as usual. Everything headed for the secondary side is answered as an unsupported request. The reset affects only this port. Link training, the physical layer and the real queue are outside the block and are reached through simple level and strobe ports.

Top module: `dsb_reset_seq`

## Requirements
- R1: After a synchronous active-low reset, `hot_rst_req`, `q_discard`, `resp_valid` and `resp_ur` are 0, the block is idle, and every request kind completes normally.
- R2: `hot_rst_req` is 1 in the cycle after any clock edge that samples both `sbr_ctl` and `link_up` high. It stays 1 while both stay high, and it falls one cycle after `sbr_ctl` is sampled low.
- R3: `hot_rst_req` is 0 in the cycle after any edge that samples `link_up` low, including the cycle in which the sequence starts with the link down.
- R4: `q_discard` is 1 exactly in the cycles where the block is in its flush phase and `q_not_empty` is 1. Outside the flush phase it is 0 whatever `q_not_empty` does.
- R5: The signalling phase lasts one cycle. Counting from the edge that first samples `sbr_ctl` high while idle, the flush phase begins after the second clock edge.
- R6: The block leaves the flush phase only on an edge that samples `q_flush_ack` high. If `sbr_ctl` is still 1 at that edge, the block holds in reset until an edge samples `sbr_ctl` low.
- R7: If `sbr_ctl` is cleared before the flush is acknowledged, the flush phase goes on, discarding and answering requests as in reset, until `q_flush_ack` arrives. The block then resumes without holding.
- R8: A request with `req_kind` = 2'b00 (Type 0 configuration to the port itself) always gets `resp_ur` = 0, in every phase.
- R9: Every request sampled with `req_valid` = 1 gets `resp_valid` = 1 on the next cycle. `resp_ur` is 1 when the request was sampled in the signalling, flush or hold phase and `req_kind` is 2'b01 (Type 1 configuration), 2'b10 (memory) or 2'b11 (I/O or message). In all other cases `resp_ur` is 0.
- R10: A request sampled on the edge that first sees `sbr_ctl` low in the hold phase is still answered as unsupported. A request sampled on the following edge completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sbr_ctl | input | 1 | Software secondary bus reset control bit |
| link_up | input | 1 | Link layer reports the link as up |
| q_not_empty | input | 1 | Ingress queue still holds packets from this port |
| q_flush_ack | input | 1 | Queue confirms that the flush is done |
| req_valid | input | 1 | An incoming request is presented this cycle |
| req_kind | input | 2 | Request class: 00 cfg type 0 to port, 01 cfg type 1, 10 memory, 11 I/O or message |
| hot_rst_req | output | 1 | Ask link layer to send training sets with hot reset set |
| q_discard | output | 1 | Discard one queued packet this cycle |
| resp_valid | output | 1 | Response class valid (one cycle after request) |
| resp_ur | output | 1 | 1: answer as unsupported request, 0: complete normally |

## Verification
Two events can meet in one cycle: the queue's flush acknowledge and software clearing the control bit. The bench makes this happen by raising `q_flush_ack`, dropping `sbr_ctl` and presenting a Type 1 request all at the same edge. The check is that this request is still answered unsupported, that discarding stops at once, that the hold phase is skipped, and that the next request completes normally. A second overlap puts a request on the very edge where the clear is first seen in the hold phase. The bench then checks the one-cycle boundary between unsupported and normal answers.

// File: rtl/dsbr_pkg.sv
// Package: shared phase and request-class types for the downstream
// secondary bus reset sequencer. Assumes a 2-bit request class code.
package dsbr_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SEND   = 3'd1,
        PH_FLUSH  = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RESUME = 3'd4
    } dsbr_phase_e;

    typedef enum logic [KIND_W-1:0] {
        RK_CFG0  = 2'b00,
        RK_CFG1  = 2'b01,
        RK_MEM   = 2'b10,
        RK_OTHER = 2'b11
    } req_kind_e;
endpackage

// File: rtl/dsbr_phase_fsm.sv
// Module: phase sequencer. Walks idle -> signal -> flush -> hold -> resume.
// Assumes sbr_ctl is synchronous to clk; q_flush_ack may be a one-cycle
// pulse and is only looked at during the flush phase.
module dsbr_phase_fsm
    import dsbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sbr_ctl,
    input  logic        q_not_empty,
    input  logic        q_flush_ack,
    output dsbr_phase_e phase,
    output logic        in_reset,
    output logic        q_discard
);
    dsbr_phase_e phase_q, phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (sbr_ctl) phase_d = PH_SEND;
            PH_SEND:   phase_d = PH_FLUSH;
            PH_FLUSH:  if (q_flush_ack) phase_d = sbr_ctl ? PH_HOLD : PH_RESUME;
            PH_HOLD:   if (!sbr_ctl) phase_d = PH_RESUME;
            PH_RESUME: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Outputs decoded from the current phase.
    always_comb begin
        phase     = phase_q;
        in_reset  = (phase_q == PH_SEND) || (phase_q == PH_FLUSH) || (phase_q == PH_HOLD);
        q_discard = (phase_q == PH_FLUSH) && q_not_empty;
    end
endmodule

// File: rtl/dsbr_hotrst.sv
// Module: hot-reset request register. Requests training sets with the
// hot-reset bit for as long as the control bit is set and the link is up.
// Assumes the link layer samples the request level, not an edge.
module dsbr_hotrst (
    input  logic clk,
    input  logic rst_n,
    input  logic sbr_ctl,
    input  logic link_up,
    output logic hot_rst_req
);
    // Register the request from control bit and link state.
    always_ff @(posedge clk) begin
        if (!rst_n) hot_rst_req <= 1'b0;
        else        hot_rst_req <= sbr_ctl && link_up;
    end
endmodule

// File: rtl/dsbr_req_class.sv
// Module: request classifier. Registers one response class per request.
// Assumes requests arrive at most one per cycle and in_reset reflects the
// phase at the sampling edge.
module dsbr_req_class
    import dsbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_reset,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    output logic              resp_valid,
    output logic              resp_ur
);
    logic own_cfg;

    // Type 0 config to the port's own bridge is always served.
    always_comb own_cfg = (req_kind == RK_CFG0);

    // Register the response class one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ur    <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_ur    <= req_valid && in_reset && !own_cfg;
        end
    end
endmodule

// File: rtl/dsb_reset_seq.sv
// Module: top of the downstream secondary bus reset sequencer for one port.
// Ties the phase sequencer, hot-reset request and request classifier
// together. Assumes all inputs are synchronous to clk.
module dsb_reset_seq
    import dsbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbr_ctl,
    input  logic              link_up,
    input  logic              q_not_empty,
    input  logic              q_flush_ack,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    output logic              hot_rst_req,
    output logic              q_discard,
    output logic              resp_valid,
    output logic              resp_ur
);
    dsbr_phase_e phase;
    logic        in_reset;

    dsbr_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sbr_ctl     (sbr_ctl),
        .q_not_empty (q_not_empty),
        .q_flush_ack (q_flush_ack),
        .phase       (phase),
        .in_reset    (in_reset),
        .q_discard   (q_discard)
    );

    dsbr_hotrst u_hot (
        .clk         (clk),
        .rst_n       (rst_n),
        .sbr_ctl     (sbr_ctl),
        .link_up     (link_up),
        .hot_rst_req (hot_rst_req)
    );

    dsbr_req_class u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_reset   (in_reset),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .resp_valid (resp_valid),
        .resp_ur    (resp_ur)
    );
endmodule

// File: rtl/dsbr_chk.sv
// Module: assertion checker for dsb_reset_seq, attached by bind below.
// Assumes it sees the top's ports and its internal phase signal.
module dsbr_chk
    import dsbr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sbr_ctl,
    input logic              link_up,
    input logic              q_flush_ack,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic              hot_rst_req,
    input logic              q_discard,
    input logic              resp_valid,
    input logic              resp_ur,
    input dsbr_phase_e       phase
);
    // R2
    hot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbr_ctl && link_up) |=> hot_rst_req);
    // R3
    hot_link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !hot_rst_req);
    // R4
    discard_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_discard |-> (phase == PH_FLUSH));
    // R5
    send_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SEND) |=> (phase == PH_FLUSH));
    // R6
    flush_wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FLUSH && !q_flush_ack) |=> (phase == PH_FLUSH));
    // R6
    hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && sbr_ctl) |=> (phase == PH_HOLD));
    // R7
    early_clear_skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FLUSH && q_flush_ack && !sbr_ctl) |=> (phase == PH_RESUME));
    // R8
    own_cfg_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == RK_CFG0) |=> !resp_ur);
    // R9
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R10
    idle_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (phase == PH_IDLE || phase == PH_RESUME)) |=> !resp_ur);
endmodule

bind dsb_reset_seq dsbr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sbr_ctl     (sbr_ctl),
    .link_up     (link_up),
    .q_flush_ack (q_flush_ack),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .hot_rst_req (hot_rst_req),
    .q_discard   (q_discard),
    .resp_valid  (resp_valid),
    .resp_ur     (resp_ur),
    .phase       (phase)
);

// File: tb/sim_dsb_reset_seq.sv
`timescale 1ns/1ps
// Bench: scoreboard for dsb_reset_seq. A driver task queues the expected
// response class per request; a monitor pops and compares on each response.
module sim_dsb_reset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sbr_ctl = 1'b0;
    logic       link_up = 1'b0;
    logic       q_not_empty = 1'b1;
    logic       q_flush_ack = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       hot_rst_req, q_discard, resp_valid, resp_ur;

    int   n_chk = 0;
    int   n_fail = 0;
    logic exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    dsb_reset_seq u0 (
        .clk(clk), .rst_n(rst_n), .sbr_ctl(sbr_ctl), .link_up(link_up),
        .q_not_empty(q_not_empty), .q_flush_ack(q_flush_ack),
        .req_valid(req_valid), .req_kind(req_kind),
        .hot_rst_req(hot_rst_req), .q_discard(q_discard),
        .resp_valid(resp_valid), .resp_ur(resp_ur)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: present one request for one cycle and queue its expected class.
    task automatic issue(input logic [1:0] k, input logic ur, input string tag);
        req_valid = 1'b1;
        req_kind  = k;
        exp_q.push_back(ur);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Monitor: compare every response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected response", 1'b1, 1'b0);
            end else begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, resp_ur, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1 hot_rst_req", hot_rst_req, 1'b0);
        chk("R1 q_discard", q_discard, 1'b0);
        chk("R1 resp_valid", resp_valid, 1'b0);
        issue(2'b00, 1'b0, "R1 idle cfg0");
        issue(2'b01, 1'b0, "R1 idle cfg1");
        issue(2'b10, 1'b0, "R9 idle mem");
        issue(2'b11, 1'b0, "R9 idle other");

        // Sequence with link up, ack while bit still set
        link_up = 1'b1;
        sbr_ctl = 1'b1;
        @(negedge clk);
        chk("R2 hot after set", hot_rst_req, 1'b1);
        chk("R5 no discard in signal phase", q_discard, 1'b0);
        issue(2'b10, 1'b1, "R9 mem in signal phase");
        chk("R5 flush begins", q_discard, 1'b1);
        repeat (2) @(negedge clk);
        chk("R4 discard while queue holds", q_discard, 1'b1);
        q_not_empty = 1'b0;
        #1;
        chk("R4 no discard on empty queue", q_discard, 1'b0);
        issue(2'b00, 1'b0, "R8 cfg0 in flush");
        issue(2'b01, 1'b1, "R9 cfg1 in flush");
        link_up = 1'b0;
        @(negedge clk);
        chk("R3 hot drops with link", hot_rst_req, 1'b0);
        link_up = 1'b1;
        @(negedge clk);
        chk("R2 hot back with link", hot_rst_req, 1'b1);
        q_not_empty = 1'b1;
        q_flush_ack = 1'b1;
        @(negedge clk);
        q_flush_ack = 1'b0;
        chk("R6 no discard in hold", q_discard, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 still holding", q_discard, 1'b0);
        issue(2'b10, 1'b1, "R6 mem in hold");
        issue(2'b00, 1'b0, "R8 cfg0 in hold");
        chk("R2 hot held", hot_rst_req, 1'b1);
        sbr_ctl = 1'b0;
        issue(2'b11, 1'b1, "R10 request on clear edge");
        chk("R2 hot falls after clear", hot_rst_req, 1'b0);
        issue(2'b11, 1'b0, "R10 request after clear");
        issue(2'b01, 1'b0, "R9 idle again");

        // Clear before flush ack, link down
        link_up = 1'b0;
        sbr_ctl = 1'b1;
        @(negedge clk);
        chk("R3 no hot with link down", hot_rst_req, 1'b0);
        @(negedge clk);
        sbr_ctl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 flush continues after clear", q_discard, 1'b1);
        issue(2'b01, 1'b1, "R7 cfg1 during late flush");
        q_flush_ack = 1'b1;
        @(negedge clk);
        q_flush_ack = 1'b0;
        chk("R7 discard ends at ack", q_discard, 1'b0);
        issue(2'b10, 1'b0, "R7 normal after ack");

        // Ack and clear on the same edge
        link_up = 1'b1;
        sbr_ctl = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 discard in flush", q_discard, 1'b1);
        q_flush_ack = 1'b1;
        sbr_ctl = 1'b0;
        issue(2'b01, 1'b1, "R6 request on ack edge");
        q_flush_ack = 1'b0;
        chk("R7 no discard after joint edge", q_discard, 1'b0);
        chk("R2 hot off after joint edge", hot_rst_req, 1'b0);
        issue(2'b01, 1'b0, "R10 normal after joint edge");
        repeat (3) @(negedge clk);
        chk("R9 all responses seen", exp_q.size() == 0, 1'b1);
        report();
        $finish;
    end
endmodule